// File: doc/BRIEF.md
# Parked Shared-Bus Arbiter

This block decides, in every clock cycle, which agent may drive a shared address bus. Up to four processor ports and one system controller each raise a request line. Every request passes through a register before arbitration uses it. A plain request therefore follows request, wait, drive: the grant appears two cycles after the request is first driven.

The bus parks on the processor port that drove it most recently. That port may request and drive in the very next cycle, provided nobody else requested in the cycle before and nobody else requests alongside it. The controller outranks the ports and always takes the full latency. It is never recorded as the parked port. Ports compete round-robin, starting with the port after the parked one. For 44 cycles after reset is released, every request input is ignored.

An owner keeps the bus for as long as its registered request stays high. It gives the bus up by dropping its request. Any pending request is then served at once.

Top module: `bus_park_arbiter`

## Requirements
- R1: While reset is low, and right after it is released, `grant` is all zero and `last_port` is 0.
- R2: Requests are ignored until 44 rising edges have passed since reset release. A request held from release onward gets no grant after edge 44, and it gets its grant at edge 45.
- R3: Fast path: the bus is idle, no request was seen in the previous cycle, and the only new request comes from port `last_port`. That port is then granted at the first rising edge after it raises the request.
- R4: Any other request that finds the bus idle is granted one cycle after its registered copy is seen, that is, at the second rising edge after it is raised.
- R5: The fast path is cancelled if any other request (port or controller) was present in the previous cycle, or is present in the same cycle. The parked port then takes the normal path of R4 or waits for the current owner.
- R6: When the controller and ports compete, the controller wins. While the controller holds the grant, and when it releases it, `last_port` keeps the value of the port that drove before it.
- R7: Competing ports are served in round-robin order, starting at `last_port`+1 (modulo 4) and ending at `last_port`.
- R8: An owner keeps the grant while its registered request is high. Once that request is seen low, the grant passes at once to the winner among the pending registered requests, or goes idle if none is pending.
- R9: `last_port` changes only when a processor port is newly granted. Cycles with no request leave it unchanged.
- R10: `grant` is one-hot or zero: bits 0 to 3 are ports 0 to 3, and bit 4 is the controller. `cur_drv` is 0 to 3 for a port, 4 for the controller and 5 when the bus is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| port_req | input | 4 | Request line of each processor port |
| ctl_req | input | 1 | Request line of the system controller |
| grant | output | 5 | One-hot bus grant, bit 4 is the controller |
| cur_drv | output | 3 | Encoded current driver, 5 when idle |
| last_port | output | 2 | Parked processor port |

## Verification
A fast-path grant is due at the first edge after the request is raised. A normal grant is due at the second edge, and a release takes effect two edges after the owner drops its request. The quiet window closes at edge 44. The bench drives inputs on falling edges and compares each vector's expected grant, driver code and parked port on the next falling edge. That sample point lies after exactly one register stage. The hand-computed table therefore places every result in its cycle: the fast path, the fallback after a controller request, simultaneous requests, controller takeover and round-robin wrap. Directed steps cover the quiet window at edges 44 and 45, and reset applied in mid-run.

// File: rtl/bpa_pkg.sv
`timescale 1ns/1ps
package bpa_pkg;
  // decision taken at each clock edge for the bus owner
  typedef enum logic [1:0] {
    PICK_HOLD = 2'd0,
    PICK_FAST = 2'd1,
    PICK_ARB  = 2'd2,
    PICK_NONE = 2'd3
  } pick_e;
endpackage

// File: rtl/bpa_quiet_gate.sv
`timescale 1ns/1ps
module bpa_quiet_gate #(
  parameter int QUIET_CYC = 44
) (
  input  logic clk,
  input  logic rst_n,
  output logic open
);
  localparam int CW = $clog2(QUIET_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign open   = (cnt_q == CW'(QUIET_CYC));
  assign cnt_en = !open;

  always_comb begin
    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bpa_req_sample.sv
`timescale 1ns/1ps
module bpa_req_sample #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate,
  input  logic [W-1:0] raw,
  output logic [W-1:0] masked,
  output logic [W-1:0] req_q
);
  assign masked = raw & {W{gate}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= masked;
  end
endmodule

// File: rtl/bpa_rr_pick.sv
`timescale 1ns/1ps
module bpa_rr_pick #(
  parameter int NPORTS = 4,
  parameter int PID_W  = 2
) (
  input  logic [NPORTS-1:0] req,
  input  logic [PID_W-1:0]  last,
  output logic              found,
  output logic [PID_W-1:0]  idx
);
  // search from last+NPORTS down to last+1 so the nearest follower wins
  always_comb begin
    found = 1'b0;
    idx   = last;
    for (int k = NPORTS; k >= 1; k--) begin
      int c;
      c = (int'(last) + k) % NPORTS;
      if (req[c]) begin
        found = 1'b1;
        idx   = PID_W'(c);
      end
    end
  end
endmodule

// File: rtl/bus_park_arbiter.sv
`timescale 1ns/1ps
module bus_park_arbiter #(
  parameter int NPORTS    = 4,
  parameter int QUIET_CYC = 44,
  localparam int AGT   = NPORTS + 1,
  localparam int DRV_W = $clog2(NPORTS + 2),
  localparam int PID_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] port_req,
  input  logic              ctl_req,
  output logic [AGT-1:0]    grant,
  output logic [DRV_W-1:0]  cur_drv,
  output logic [PID_W-1:0]  last_port
);
  import bpa_pkg::*;

  localparam int CTL  = NPORTS;
  localparam int IDLE = NPORTS + 1;

  logic             gate_open;
  logic [AGT-1:0]   req_raw, req_now, req_q;
  logic             own_vld_q, own_vld_d;
  logic [DRV_W-1:0] own_id_q, own_id_d;
  logic [PID_W-1:0] last_q, last_d;
  logic [AGT-1:0]   own_vec;
  logic             rr_found;
  logic [PID_W-1:0] rr_idx;
  logic             hold, fast, upd_en;
  pick_e            pick;

  bpa_quiet_gate #(.QUIET_CYC(QUIET_CYC)) u_quiet (
    .clk  (clk),
    .rst_n(rst_n),
    .open (gate_open)
  );

  assign req_raw = {ctl_req, port_req};

  bpa_req_sample #(.W(AGT)) u_sample (
    .clk   (clk),
    .rst_n (rst_n),
    .gate  (gate_open),
    .raw   (req_raw),
    .masked(req_now),
    .req_q (req_q)
  );

  bpa_rr_pick #(.NPORTS(NPORTS), .PID_W(PID_W)) u_rr (
    .req  (req_q[NPORTS-1:0]),
    .last (last_q),
    .found(rr_found),
    .idx  (rr_idx)
  );

  assign own_vec = own_vld_q ? (AGT'(1) << own_id_q) : '0;
  assign hold    = |(req_q & own_vec);
  // parked port alone, on an idle bus, after a quiet cycle
  assign fast    = !own_vld_q && (req_q == '0) &&
                   (req_now == (AGT'(1) << last_q));

  always_comb begin
    if (hold)                      pick = PICK_HOLD;
    else if (fast)                 pick = PICK_FAST;
    else if (req_q[CTL] || rr_found) pick = PICK_ARB;
    else                           pick = PICK_NONE;
  end

  always_comb begin
    own_vld_d = own_vld_q;
    own_id_d  = own_id_q;
    last_d    = last_q;
    unique case (pick)
      PICK_HOLD: ;
      PICK_FAST: begin
        own_vld_d = 1'b1;
        own_id_d  = DRV_W'(last_q);
      end
      PICK_ARB: begin
        own_vld_d = 1'b1;
        if (req_q[CTL]) begin
          own_id_d = DRV_W'(CTL);
        end else begin
          own_id_d = DRV_W'(rr_idx);
          last_d   = rr_idx;
        end
      end
      default: begin
        own_vld_d = 1'b0;
        own_id_d  = DRV_W'(IDLE);
      end
    endcase
  end

  assign upd_en = (pick != PICK_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_vld_q <= 1'b0;
      own_id_q  <= DRV_W'(IDLE);
      last_q    <= '0;
    end else if (upd_en) begin
      own_vld_q <= own_vld_d;
      own_id_q  <= own_id_d;
      last_q    <= last_d;
    end
  end

  assign grant     = own_vec;
  assign cur_drv   = own_id_q;
  assign last_port = last_q;
endmodule

// File: rtl/bpa_checker.sv
`timescale 1ns/1ps
module bpa_checker #(
  parameter int NPORTS = 4,
  localparam int AGT   = NPORTS + 1,
  localparam int DRV_W = $clog2(NPORTS + 2),
  localparam int PID_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AGT-1:0]   grant,
  input logic [DRV_W-1:0] cur_drv,
  input logic [PID_W-1:0] last_port,
  input logic [AGT-1:0]   req_q,
  input logic             gate_open
);
  // R10
  a_r10_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R10
  a_r10_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) == (cur_drv == DRV_W'(NPORTS + 1)));

  // R2
  a_r2_quiet_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_open |=> (grant == '0));

  // R6
  a_r6_ctl_not_parked: assert property (@(posedge clk) disable iff (!rst_n)
    grant[NPORTS] |-> $stable(last_port));

  // R8
  a_r8_owner_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_q & grant) != '0) |=> $stable(grant));

  // R9
  a_r9_last_moves_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(last_port) |-> grant[last_port]);
endmodule

bind bus_park_arbiter bpa_checker #(.NPORTS(NPORTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .grant    (grant),
  .cur_drv  (cur_drv),
  .last_port(last_port),
  .req_q    (req_q),
  .gate_open(gate_open)
);

// File: tb/test_bus_park_arbiter.sv
`timescale 1ns/1ps
module test_bus_park_arbiter;
  logic       clk;
  logic       rst_n;
  logic [3:0] port_req;
  logic       ctl_req;
  logic [4:0] grant;
  logic [2:0] cur_drv;
  logic [1:0] last_port;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  bus_park_arbiter i_bus_park_arbiter (
    .clk(clk), .rst_n(rst_n), .port_req(port_req), .ctl_req(ctl_req),
    .grant(grant), .cur_drv(cur_drv), .last_port(last_port)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {port_req, ctl_req, expected grant, expected last_port}
  localparam int NV = 35;
  localparam logic [11:0] VEC [NV] = '{
    12'b0001_0_00001_00, 12'b0001_0_00001_00, 12'b0000_0_00001_00,
    12'b0000_0_00000_00, 12'b0010_0_00000_00, 12'b0010_0_00010_01,
    12'b0000_0_00010_01, 12'b0000_0_00000_01, 12'b0010_0_00010_01,
    12'b0000_0_00010_01, 12'b0000_0_00000_01, 12'b0000_1_00000_01,
    12'b0010_0_10000_01, 12'b0010_0_00010_01, 12'b0000_0_00010_01,
    12'b0000_0_00000_01, 12'b0011_0_00000_01, 12'b0011_0_00001_00,
    12'b0010_0_00001_00, 12'b0010_0_00010_01, 12'b0000_0_00010_01,
    12'b0000_0_00000_01, 12'b0100_1_00000_01, 12'b0100_1_10000_01,
    12'b0100_0_10000_01, 12'b0100_0_00100_10, 12'b0000_0_00100_10,
    12'b0000_0_00000_10, 12'b1001_0_00000_10, 12'b1001_0_01000_11,
    12'b0001_0_01000_11, 12'b0001_0_00001_00, 12'b0000_0_00001_00,
    12'b0000_0_00000_00, 12'b0000_0_00000_00
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 8:                   return "R3";
      4, 5:                   return "R4";
      11, 12, 13, 16:         return "R5";
      22, 23, 24, 25:         return "R6";
      17, 28, 29, 31:         return "R7";
      7, 10, 15, 21, 27, 33, 34: return "R9";
      default:                return "R8";
    endcase
  endfunction

  // R10 encoding: ports 0..3, controller 4, idle 5
  function automatic logic [2:0] exp_cur(logic [4:0] g);
    if (g == 5'b0) return 3'd5;
    for (int b = 0; b < 5; b++) if (g[b]) return 3'(b);
    return 3'd5;
  endfunction

  task automatic check(string tag, logic [4:0] eg, logic [1:0] el);
    total++;
    if (grant !== eg || last_port !== el || cur_drv !== exp_cur(eg)) begin
      bad++;
      $display("FAIL %s: grant=%b cur=%0d last=%0d expected grant=%b cur=%0d last=%0d",
               tag, grant, cur_drv, last_port, eg, exp_cur(eg), el);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 5'b0, 2'd0);
    rst_n = 1'b1;
    #0.5;
    check("R1 after release", 5'b0, 2'd0);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    port_req = 4'b0;
    ctl_req  = 1'b0;

    // R2: request held from release is ignored through edge 44
    do_reset();
    port_req = 4'b0001;
    repeat (44) @(posedge clk);
    @(negedge clk);
    check("R2 edge 44", 5'b0, 2'd0);
    @(negedge clk);
    check("R2 edge 45", 5'b00001, 2'd0);

    // R1: asynchronous reset while port 0 owns the bus
    #1 rst_n = 1'b0;
    #0.5;
    check("R1 async", 5'b0, 2'd0);
    port_req = 4'b0;

    do_reset();
    repeat (44) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      port_req = VEC[i][11:8];
      ctl_req  = VEC[i][7];
      @(negedge clk);
      check($sformatf("%s vector %0d", vec_tag(i), i), VEC[i][6:2], VEC[i][1:0]);
    end

    // R1: reset after traffic brings last_port back to 0
    port_req = 4'b1000;
    repeat (3) @(negedge clk);
    check("R7 port 3 granted", 5'b01000, 2'd3);
    do_reset();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule